// File: doc/BRIEF.md
# Power-Mode Peripheral Clock Enable Controller

This block decides, cycle by cycle, which peripherals receive a clock. Software programs three enable masks, each with one bit per peripheral: one used while the processor runs, one for light sleep, and one for deep sleep. A small mode machine follows the processor. A wait-for-interrupt event moves it into light sleep, or into deep sleep when the deep-sleep request bit is set. Any pending interrupt brings it back to run. The masks for the low-power modes apply only when automatic gating is switched on. Otherwise the run mask stays in force in every mode.

All enable outputs come straight from flops. This lets them drive latch-based clock-gate cells directly. The block also drops the processor clock enable in both low-power modes. It raises a bus fault whenever the bus addresses a peripheral whose enable is low.

A small register port writes and reads the three masks and a control word. The control word holds the automatic-gating switch.

Top module: `periph_clk_gate`

## Requirements
- R1: After reset, all three masks and the automatic-gating bit read 0, `periph_clk_en` is 0, `power_mode` is run (2'd0) and `cpu_clk_en` is 1.
- R2: While `power_mode` is run (2'd0), `periph_clk_en` equals the run mask.
- R3: In run mode, `wfi_evt` high with `deep_req` low and `irq_pend` low moves `power_mode` to light sleep (2'd1) at the next edge, and `cpu_clk_en` goes to 0 at that same edge.
- R4: In run mode, `wfi_evt` high with `deep_req` high and `irq_pend` low moves `power_mode` to deep sleep (2'd2) at the next edge, with `cpu_clk_en` 0.
- R5: With automatic gating on (control bit 0 = 1), `periph_clk_en` equals the light-sleep mask in light sleep and the deep-sleep mask in deep sleep.
- R6: With automatic gating off, `periph_clk_en` equals the run mask in both low-power modes.
- R7: In either low-power mode, `irq_pend` high returns `power_mode` to run at the next edge with `cpu_clk_en` 1. In run mode, `wfi_evt` together with `irq_pend` leaves the mode at run.
- R8: `bus_fault` is high in the same cycle as `bus_req` exactly when `periph_clk_en[bus_sel]` is 0.
- R9: `cfg_wr` writes `cfg_wdata` at the next edge to the register chosen by `cfg_addr`: 0 = run mask, 1 = light-sleep mask, 2 = deep-sleep mask, 3 = control (bit 0 = automatic gating, other bits read 0). `cfg_rdata` shows the currently stored contents of the register at `cfg_addr` in the same cycle.
- R10: `periph_clk_en`, `cpu_clk_en` and `power_mode` change only at rising clock edges. They never follow an input change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wfi_evt | input | 1 | Processor wait-for-interrupt event |
| deep_req | input | 1 | Deep-sleep request bit from the processor |
| irq_pend | input | 1 | Any interrupt pending |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | N | Write data |
| cfg_rdata | output | N | Read data of selected register |
| bus_req | input | 1 | Bus access to a peripheral |
| bus_sel | input | SW | Index of the accessed peripheral |
| bus_fault | output | 1 | Access to an unclocked peripheral |
| power_mode | output | 2 | 0 run, 1 light sleep, 2 deep sleep |
| cpu_clk_en | output | 1 | Processor and memory clock enable |
| periph_clk_en | output | N | Per-peripheral clock enables |

## Verification
The assertions assume that `bus_sel` always names an existing peripheral. They also assume that `irq_pend` alone decides wake-up, so a wait event that arrives during sleep is simply ignored. The random stimulus draws `bus_sel` modulo N and drives every input at the falling edge, so all inputs are settled at each rising edge. Wait events, interrupts and writes are drawn at different rates, so the stimulus spends long stretches in each mode while the masks and the gating switch keep changing under it.

// File: rtl/periph_clk_gate.sv
module periph_clk_gate #(
  parameter int N = 8,
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wfi_evt,
  input  logic          deep_req,
  input  logic          irq_pend,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_addr,
  input  logic [N-1:0]  cfg_wdata,
  output logic [N-1:0]  cfg_rdata,
  input  logic          bus_req,
  input  logic [SW-1:0] bus_sel,
  output logic          bus_fault,
  output logic [1:0]    power_mode,
  output logic          cpu_clk_en,
  output logic [N-1:0]  periph_clk_en
);
  localparam logic [1:0] M_RUN = 2'd0, M_LITE = 2'd1, M_DEEP = 2'd2;

  logic [N-1:0] run_q, lite_q, deep_q, run_d, lite_d, deep_d, en_d;
  logic         auto_q, auto_d;
  logic [1:0]   mode_d;

  assign run_d  = (cfg_wr && cfg_addr == 2'd0) ? cfg_wdata : run_q;
  assign lite_d = (cfg_wr && cfg_addr == 2'd1) ? cfg_wdata : lite_q;
  assign deep_d = (cfg_wr && cfg_addr == 2'd2) ? cfg_wdata : deep_q;
  assign auto_d = (cfg_wr && cfg_addr == 2'd3) ? cfg_wdata[0] : auto_q;

  always_comb begin
    mode_d = power_mode;
    if (power_mode == M_RUN) begin
      if (wfi_evt && !irq_pend) mode_d = deep_req ? M_DEEP : M_LITE;
    end else if (irq_pend) begin
      mode_d = M_RUN;
    end
  end

  always_comb begin
    if (mode_d == M_RUN || !auto_d) en_d = run_d;
    else if (mode_d == M_LITE)      en_d = lite_d;
    else                            en_d = deep_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q         <= '0;
      lite_q        <= '0;
      deep_q        <= '0;
      auto_q        <= 1'b0;
      power_mode    <= M_RUN;
      cpu_clk_en    <= 1'b1;
      periph_clk_en <= '0;
    end else begin
      run_q         <= run_d;
      lite_q        <= lite_d;
      deep_q        <= deep_d;
      auto_q        <= auto_d;
      power_mode    <= mode_d;
      cpu_clk_en    <= (mode_d == M_RUN);
      periph_clk_en <= en_d;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      2'd0:    cfg_rdata = run_q;
      2'd1:    cfg_rdata = lite_q;
      2'd2:    cfg_rdata = deep_q;
      default: cfg_rdata[0] = auto_q;
    endcase
  end

  assign bus_fault = bus_req && !((int'(bus_sel) < N) && periph_clk_en[bus_sel]);
endmodule

// File: rtl/periph_clk_gate_chk.sv
module periph_clk_gate_chk #(
  parameter int N = 8,
  parameter int SW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wfi_evt,
  input logic          deep_req,
  input logic          irq_pend,
  input logic          bus_req,
  input logic [SW-1:0] bus_sel,
  input logic          bus_fault,
  input logic [1:0]    power_mode,
  input logic          cpu_clk_en,
  input logic [N-1:0]  periph_clk_en,
  input logic [N-1:0]  run_q,
  input logic [N-1:0]  lite_q,
  input logic [N-1:0]  deep_q,
  input logic          auto_q
);
  p_run_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    power_mode == 2'd0 |-> periph_clk_en == run_q);

  p_lite_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (power_mode == 2'd0 && wfi_evt && !deep_req && !irq_pend) |=> (power_mode == 2'd1 && !cpu_clk_en));

  p_deep_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (power_mode == 2'd0 && wfi_evt && deep_req && !irq_pend) |=> (power_mode == 2'd2 && !cpu_clk_en));

  p_lite_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (power_mode == 2'd1 && auto_q) |-> periph_clk_en == lite_q);

  p_no_auto_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (power_mode != 2'd0 && !auto_q) |-> periph_clk_en == run_q);

  p_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (power_mode != 2'd0 && irq_pend) |=> (power_mode == 2'd0 && cpu_clk_en));

  p_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (power_mode == 2'd0 && bus_req && !run_q[bus_sel]) |-> bus_fault);
endmodule

bind periph_clk_gate periph_clk_gate_chk #(.N(N), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wfi_evt(wfi_evt), .deep_req(deep_req),
  .irq_pend(irq_pend), .bus_req(bus_req), .bus_sel(bus_sel),
  .bus_fault(bus_fault), .power_mode(power_mode), .cpu_clk_en(cpu_clk_en),
  .periph_clk_en(periph_clk_en), .run_q(run_q), .lite_q(lite_q),
  .deep_q(deep_q), .auto_q(auto_q)
);

// File: tb/periph_clk_gate_tb.sv
`timescale 1ns/1ps
module periph_clk_gate_tb;
  localparam int N = 8;
  localparam int SW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wfi_evt = 0, deep_req = 0, irq_pend = 0, cfg_wr = 0, bus_req = 0;
  logic [1:0] cfg_addr = '0;
  logic [N-1:0] cfg_wdata = '0;
  logic [SW-1:0] bus_sel = '0;
  logic [N-1:0] cfg_rdata, periph_clk_en;
  logic bus_fault, cpu_clk_en;
  logic [1:0] power_mode;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [N-1:0] m_run = '0, m_lite = '0, m_deep = '0, m_en = '0;
  logic m_auto = 0;
  logic [1:0] m_mode = 2'd0;

  always #5 clk = ~clk;

  periph_clk_gate #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .wfi_evt(wfi_evt), .deep_req(deep_req),
    .irq_pend(irq_pend), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_req(bus_req),
    .bus_sel(bus_sel), .bus_fault(bus_fault), .power_mode(power_mode),
    .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return m_run;
      2'd1: return m_lite;
      2'd2: return m_deep;
      default: return N'(m_auto);
    endcase
  endfunction

  function automatic logic [N-1:0] exp_en(input logic [1:0] md);
    if (md == 2'd0 || !m_auto) return m_run;
    return (md == 2'd1) ? m_lite : m_deep;
  endfunction

  task automatic step(input bit w, input bit d, input bit i, input bit cw,
                      input logic [1:0] a, input logic [N-1:0] wd,
                      input bit br, input logic [SW-1:0] bs);
    logic [N-1:0] en_before;
    logic [1:0] mode_before;
    string mtag;
    @(negedge clk);
    en_before = periph_clk_en;
    mode_before = power_mode;
    wfi_evt = w; deep_req = d; irq_pend = i; cfg_wr = cw;
    cfg_addr = a; cfg_wdata = wd; bus_req = br; bus_sel = bs;
    #1;
    chk(periph_clk_en == en_before && power_mode == mode_before, "R10", periph_clk_en, en_before);
    chk(cfg_rdata == exp_rd(a), "R9", cfg_rdata, exp_rd(a));
    chk(bus_fault == (br && !m_en[bs]), "R8", bus_fault, br && !m_en[bs]);
    mtag = "R2";
    if (m_mode == 2'd0) begin
      if (w && !i) begin
        m_mode = d ? 2'd2 : 2'd1;
        mtag = d ? "R4" : "R3";
      end else if (w) mtag = "R7";
    end else begin
      mtag = "R7";
      if (i) m_mode = 2'd0;
    end
    if (cw) begin
      case (a)
        2'd0: m_run = wd;
        2'd1: m_lite = wd;
        2'd2: m_deep = wd;
        default: m_auto = wd[0];
      endcase
    end
    m_en = exp_en(m_mode);
    @(posedge clk); #1;
    chk(power_mode == m_mode, mtag, power_mode, m_mode);
    chk(cpu_clk_en == (m_mode == 2'd0), mtag, cpu_clk_en, m_mode == 2'd0);
    chk(periph_clk_en == m_en, (m_mode == 2'd0) ? "R2" : (m_auto ? "R5" : "R6"), periph_clk_en, m_en);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(power_mode == 2'd0, "R1", power_mode, 0);
    chk(cpu_clk_en == 1'b1, "R1", cpu_clk_en, 1);
    chk(periph_clk_en == '0, "R1", periph_clk_en, 0);
    for (int k = 0; k < 4; k++) begin
      cfg_addr = k[1:0]; #1;
      chk(cfg_rdata == '0, "R1", cfg_rdata, 0);
    end
    // directed
    step(0,0,0,1,2'd0,8'hA5,0,0);
    step(0,0,0,1,2'd1,8'h3C,1,1);
    step(0,0,0,1,2'd2,8'h81,1,0);
    step(0,0,0,1,2'd3,8'hFF,1,6);
    step(0,0,0,0,2'd3,8'h00,1,7);
    step(1,0,0,0,2'd1,8'h00,1,2);   // R3 to light sleep
    step(0,0,0,0,2'd0,8'h00,1,2);   // R5 light-sleep mask
    step(0,0,1,0,2'd0,8'h00,0,0);   // R7 wake
    step(1,1,0,0,2'd2,8'h00,1,7);   // R4 to deep sleep
    step(0,0,0,1,2'd3,8'h00,1,1);   // R6 auto off in deep sleep
    step(0,0,1,0,2'd0,8'h00,0,0);
    step(1,0,1,0,2'd0,8'h00,0,0);   // R7 wfi with pending irq stays run
    step(1,1,1,0,2'd0,8'h00,1,1);
    step(1,0,0,0,2'd0,8'h00,1,0);   // R6 light sleep, run mask
    step(1,1,0,0,2'd0,8'h00,0,0);   // wait event ignored while asleep
    step(0,0,1,0,2'd0,8'h00,0,0);
    // random
    for (int n = 0; n < 3000; n++) begin
      step(($urandom % 8) == 0, $urandom % 2,
           (m_mode != 2'd0) ? (($urandom % 6) == 0) : (($urandom % 4) == 0),
           ($urandom % 3) == 0, 2'($urandom % 4), N'($urandom),
           $urandom % 2, SW'($urandom % N));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule